// File: doc/BRIEF.md
# HDLC Flag-Pattern Carrier Detect

This block decides whether a bit-serial HDLC receive path is currently looking at a live signal. It does not measure audio energy. Instead it watches the decoded bit stream for the idle fill a transmitter sends before a frame. On each bit strobe it accepts one decoded bit and one raw line bit. The decoded bit goes into a 32-bit history, and the raw bit goes into an 8-bit run register.

The carrier level rises after three flag octets (0x7E) in a row. It also rises after two all-zero octets followed by one flag, so that transmitters using non-standard zero fill are still accepted. The level falls when the last eight raw bits are all ones, which means the line shows no transitions. Both conditions are evaluated on the register contents after the current bit has been shifted in. If both hold on the same bit, the drop wins. A one-cycle change pulse marks every real change of the level, so a downstream controller can timestamp carrier on and off without comparing levels itself.

Reset clears the history. A cleared history reads as zero fill, so a single flag arriving directly after reset is enough to raise the carrier.

Top module: `flag_carrier_detect`

## Requirements
- R1: While `rst_n` is low on a rising clock edge, `carrier` and `carrier_chg` are 0 after that edge, and the history and run registers are cleared to all zeros.
- R2: Each strobed decoded bit enters history bit 31 and the older bits shift one place toward bit 0. When history bits 31..8 equal 0x7E7E7E after a strobed bit, `carrier` is 1 after that same clock edge.
- R3: When history bits 31..8 equal 0x7E0000 after a strobed bit (two zero octets, then a flag), `carrier` is 1 after that same edge. This also applies to a flag arriving directly after reset.
- R4: A single flag, or two consecutive flags, preceded by data that is neither a flag nor zero fill leaves `carrier` at 0.
- R5: When the last eight strobed raw bits are all 1, `carrier` is 0 after that edge. A run of seven ones followed by a zero leaves `carrier` unchanged.
- R6: `carrier_chg` is 1 for exactly the one cycle after an edge at which `carrier` changed, and 0 at every other time. This includes a flag match while `carrier` is already 1.
- R7: If a raise condition and the eight-ones condition hold on the same strobed bit, `carrier` stays 0 and no pulse is issued.
- R8: While `bit_vld` is low, `dec_bit` and `raw_bit` are ignored. Neither register changes, and `carrier` and `carrier_chg` do not change state (`carrier_chg` is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_vld | input | 1 | Strobe: one bit is presented this cycle |
| dec_bit | input | 1 | Decoded data bit, shifted into the history |
| raw_bit | input | 1 | Raw line bit, shifted into the transition run register |
| carrier | output | 1 | Carrier detect level |
| carrier_chg | output | 1 | One-cycle pulse when `carrier` changes |

## Verification
A history that shifted in the wrong direction, or that took a bit while the strobe was low, would show up at `carrier` within one octet. The three-flag case would either rise early after only two flags, or fail to rise on the exact 24th bit. The bench samples the level after every single bit, so an off-by-one in the evaluation point becomes visible on the edge where it occurs. A wrong run register, or a wrong priority between raise and drop, appears as a level that fails to fall on the eighth one or rises during a flag carried on an idle line. A stuck or double `carrier_chg` is caught at each bit of the sustained-flag and idle sequences.

// File: rtl/fcd_pkg.sv
// Package: shared constants and types for the flag carrier detect.
// Assumes octets are eight bits wide; everything else is parameterised
// at the top module.
package fcd_pkg;

    localparam int OCT_W = 8;

    // Decision taken by the level controller on a strobed bit.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_RAISE = 2'd1,
        ACT_DROP  = 2'd2
    } fcd_action_e;

endpackage

// File: rtl/fcd_shift_reg.sv
// Module: serial-in shift register, new bit enters at the MSB and
// older bits move toward bit 0. Exposes both the stored value and the
// value it will hold after a strobed shift, so that decisions can be
// based on post-shift contents in the same cycle.
// Assumes W >= 2. Synchronous active-low reset clears to zero.
module fcd_shift_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);

    // Purpose: form the post-shift value (or hold when not strobed).
    always_comb begin
        if (shift_en) begin
            q_next = {din, q[W-1:1]};
        end else begin
            q_next = q;
        end
    end

    // Purpose: register the shift contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/fcd_octet_matcher.sv
// Module: compares the newest RUN_OCTETS octets of a history window
// against two idle patterns: a run of flags, and zero fill capped by
// one flag (flag in the newest octet, zeros in all older ones).
// Assumes the window's MSB octet is the most recent one. Purely
// combinational.
module fcd_octet_matcher
    import fcd_pkg::*;
#(
    parameter int               RUN_OCTETS = 3,
    parameter logic [OCT_W-1:0] FLAG_OCTET = 8'h7E,
    localparam int              WIN        = RUN_OCTETS * OCT_W
) (
    input  logic [WIN-1:0] window,
    output logic           flag_run,
    output logic           zero_fill
);

    logic [RUN_OCTETS-1:0] is_flag;
    logic [RUN_OCTETS-1:0] is_zero;

    // Purpose: classify each octet of the window on its own.
    for (genvar i = 0; i < RUN_OCTETS; i++) begin : g_oct
        assign is_flag[i] = (window[i*OCT_W +: OCT_W] == FLAG_OCTET);
        assign is_zero[i] = (window[i*OCT_W +: OCT_W] == '0);
    end

    // Purpose: combine octet classes into the two idle patterns.
    assign flag_run  = &is_flag;
    assign zero_fill = is_flag[RUN_OCTETS-1] & (&is_zero[RUN_OCTETS-2:0]);

endmodule

// File: rtl/fcd_level_ctrl.sv
// Module: holds the carrier level and emits a pulse on each change.
// A drop request takes priority over a raise request. Requests are
// only honoured on strobed cycles; the pulse lasts one cycle.
// Synchronous active-low reset.
module fcd_level_ctrl
    import fcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic want_up,
    input  logic want_down,
    output logic level,
    output logic level_chg
);

    fcd_action_e action;
    logic        level_next;

    // Purpose: choose the action, drop first.
    always_comb begin
        if (!strobe) begin
            action = ACT_HOLD;
        end else if (want_down) begin
            action = ACT_DROP;
        end else if (want_up) begin
            action = ACT_RAISE;
        end else begin
            action = ACT_HOLD;
        end
    end

    // Purpose: map the action to the next level.
    always_comb begin
        case (action)
            ACT_RAISE: level_next = 1'b1;
            ACT_DROP:  level_next = 1'b0;
            default:   level_next = level;
        endcase
    end

    // Purpose: register the level and the change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level     <= 1'b0;
            level_chg <= 1'b0;
        end else begin
            level     <= level_next;
            level_chg <= (level_next != level);
        end
    end

endmodule

// File: rtl/flag_carrier_detect.sv
// Module: pattern-based carrier detect for a bit-serial HDLC receiver.
// Decoded bits build a history; raw bits build a transition run
// register. The carrier rises on a flag run or on zero fill capped by a
// flag, and falls on PAT_W raw ones. Evaluation uses post-shift
// contents. Assumes HIST_W >= RUN_OCTETS*8 and RUN_OCTETS >= 2.
module flag_carrier_detect
    import fcd_pkg::*;
#(
    parameter int               HIST_W     = 32,
    parameter int               PAT_W      = 8,
    parameter int               RUN_OCTETS = 3,
    parameter logic [OCT_W-1:0] FLAG_OCTET = 8'h7E
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic dec_bit,
    input  logic raw_bit,
    output logic carrier,
    output logic carrier_chg
);

    localparam int WIN = RUN_OCTETS * OCT_W;

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_next;
    logic [PAT_W-1:0]  pat_q;
    logic [PAT_W-1:0]  pat_next;
    logic              flag_run;
    logic              zero_fill;
    logic              idle_line;
    logic              unused_fold;

    // Purpose: decoded-bit history.
    fcd_shift_reg #(.W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_vld),
        .din      (dec_bit),
        .q        (hist_q),
        .q_next   (hist_next)
    );

    // Purpose: raw-bit transition run register.
    fcd_shift_reg #(.W(PAT_W)) u_pat (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_vld),
        .din      (raw_bit),
        .q        (pat_q),
        .q_next   (pat_next)
    );

    // Purpose: idle pattern match on the newest octets after the shift.
    fcd_octet_matcher #(
        .RUN_OCTETS (RUN_OCTETS),
        .FLAG_OCTET (FLAG_OCTET)
    ) u_match (
        .window    (hist_next[HIST_W-1 -: WIN]),
        .flag_run  (flag_run),
        .zero_fill (zero_fill)
    );

    // Purpose: no transitions over the whole run register.
    assign idle_line = &pat_next;

    // Purpose: level and change pulse.
    fcd_level_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (bit_vld),
        .want_up   (flag_run | zero_fill),
        .want_down (idle_line),
        .level     (carrier),
        .level_chg (carrier_chg)
    );

    // Purpose: fold bits that only the checker observes.
    if (HIST_W > WIN) begin : g_fold_wide
        assign unused_fold = ^{hist_q, pat_q, hist_next[HIST_W-WIN-1:0]};
    end else begin : g_fold_exact
        assign unused_fold = ^{hist_q, pat_q};
    end

endmodule

// File: rtl/fcd_checker.sv
// Checker: temporal properties of the flag carrier detect, bound to
// the top module. Observes ports plus the stored history and run
// register.
module fcd_checker #(
    parameter int         HIST_W     = 32,
    parameter int         PAT_W      = 8,
    parameter int         RUN_OCTETS = 3,
    parameter logic [7:0] FLAG_OCTET = 8'h7E
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_vld,
    input logic              carrier,
    input logic              carrier_chg,
    input logic [HIST_W-1:0] hist_q,
    input logic [PAT_W-1:0]  pat_q
);

    localparam int WIN = RUN_OCTETS * 8;

    logic [WIN-1:0] run_pat;
    logic [WIN-1:0] fill_pat;

    // Purpose: reference idle patterns, newest octet at the top.
    always_comb begin
        run_pat  = '0;
        fill_pat = '0;
        for (int i = 0; i < RUN_OCTETS; i++) begin
            run_pat[i*8 +: 8] = FLAG_OCTET;
        end
        fill_pat[WIN-1 -: 8] = FLAG_OCTET;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!carrier && !carrier_chg)); // R1

    AST_RISE_ON_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier) |-> (hist_q[HIST_W-1 -: WIN] == run_pat ||
                            hist_q[HIST_W-1 -: WIN] == fill_pat)); // R2

    AST_NO_TRANSITIONS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_q == {PAT_W{1'b1}}) |-> !carrier); // R5

    AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_chg |-> (carrier != $past(carrier))); // R6

    AST_CHANGE_HAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier != $past(carrier)) |-> carrier_chg); // R6

    AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_vld) |-> ($stable(carrier) && !carrier_chg)); // R8

endmodule

bind flag_carrier_detect fcd_checker #(
    .HIST_W     (HIST_W),
    .PAT_W      (PAT_W),
    .RUN_OCTETS (RUN_OCTETS),
    .FLAG_OCTET (FLAG_OCTET)
) u_fcd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_vld     (bit_vld),
    .carrier     (carrier),
    .carrier_chg (carrier_chg),
    .hist_q      (hist_q),
    .pat_q       (pat_q)
);

// File: tb/flag_carrier_detect_test.sv
`timescale 1ns/1ps
module flag_carrier_detect_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0;
    logic dec_bit = 1'b0;
    logic raw_bit = 1'b0;
    logic carrier;
    logic carrier_chg;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    flag_carrier_detect uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_vld     (bit_vld),
        .dec_bit     (dec_bit),
        .raw_bit     (raw_bit),
        .carrier     (carrier),
        .carrier_chg (carrier_chg)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic do_reset();
        rst_n   = 1'b0;
        bit_vld = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One strobed bit; returns at the falling edge after the capture.
    task automatic send_bit(input logic d, input logic r);
        bit_vld = 1'b1;
        dec_bit = d;
        raw_bit = r;
        @(posedge clk);
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    // LSB first, so the octet lands in history bits 31..24.
    task automatic send_octet(input logic [7:0] v, input logic raw_ones);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i], raw_ones ? 1'b1 : v[i]);
        end
    endtask

    task automatic send_prefix();
        for (int k = 0; k < 3; k++) send_octet(8'h55, 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "carrier in reset", carrier, 1'b0);
        check("R1", "carrier_chg in reset", carrier_chg, 1'b0);
        do_reset();
        check("R1", "carrier after reset", carrier, 1'b0);
    endtask

    task automatic t_flag_after_reset();
        do_reset();
        for (int i = 0; i < 7; i++) send_bit(FLAGB(i), FLAGB(i));
        check("R3", "no carrier on 7th flag bit", carrier, 1'b0);
        send_bit(1'b0, 1'b0);
        check("R3", "flag over cleared history raises", carrier, 1'b1);
        check("R6", "pulse on rise", carrier_chg, 1'b1);
    endtask

    function automatic logic FLAGB(input int i);
        logic [7:0] f;
        f = 8'h7E;
        return f[i];
    endfunction

    task automatic t_zero_fill();
        do_reset();
        send_prefix();
        send_octet(8'h00, 1'b0);
        send_octet(8'h00, 1'b0);
        for (int i = 0; i < 7; i++) send_bit(FLAGB(i), FLAGB(i));
        check("R3", "zero fill before last flag bit", carrier, 1'b0);
        send_bit(1'b0, 1'b0);
        check("R3", "zero fill plus flag raises", carrier, 1'b1);
    endtask

    task automatic t_flag_run();
        logic seen_chg;
        do_reset();
        send_prefix();
        send_octet(8'h7E, 1'b0);
        check("R4", "single flag", carrier, 1'b0);
        send_octet(8'h7E, 1'b0);
        check("R4", "two flags", carrier, 1'b0);
        for (int i = 0; i < 7; i++) send_bit(FLAGB(i), FLAGB(i));
        check("R2", "third flag not complete", carrier, 1'b0);
        send_bit(1'b0, 1'b0);
        check("R2", "three flags raise", carrier, 1'b1);
        check("R6", "pulse on three-flag rise", carrier_chg, 1'b1);
        seen_chg = 1'b0;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 8; i++) begin
                send_bit(FLAGB(i), FLAGB(i));
                seen_chg = seen_chg | carrier_chg;
            end
        end
        check("R6", "no pulse while flags continue", seen_chg, 1'b0);
        check("R2", "carrier held on flags", carrier, 1'b1);
    endtask

    task automatic t_idle_drop();
        send_octet(8'h7F, 1'b0);
        check("R5", "seven ones then zero keep carrier", carrier, 1'b1);
        for (int i = 0; i < 7; i++) send_bit(1'b1, 1'b1);
        check("R5", "seven ones keep carrier", carrier, 1'b1);
        send_bit(1'b1, 1'b1);
        check("R5", "eighth one drops carrier", carrier, 1'b0);
        check("R6", "pulse on drop", carrier_chg, 1'b1);
        send_bit(1'b0, 1'b0);
        check("R6", "pulse lasts one cycle", carrier_chg, 1'b0);
    endtask

    task automatic t_conflict();
        do_reset();
        send_prefix();
        send_octet(8'h7E, 1'b0);
        send_octet(8'h7E, 1'b0);
        send_octet(8'h7E, 1'b1);
        check("R7", "drop wins over flag run", carrier, 1'b0);
        check("R7", "no pulse on conflict", carrier_chg, 1'b0);
    endtask

    task automatic t_no_strobe();
        do_reset();
        send_prefix();
        send_octet(8'h7E, 1'b0);
        send_octet(8'h7E, 1'b0);
        for (int c = 0; c < 20; c++) begin
            dec_bit = c[0];
            raw_bit = 1'b1;
            @(negedge clk);
        end
        check("R8", "no carrier from unstrobed bits", carrier, 1'b0);
        send_octet(8'h7E, 1'b0);
        check("R8", "history intact after gap", carrier, 1'b1);
        for (int c = 0; c < 12; c++) begin
            dec_bit = 1'b1;
            raw_bit = 1'b1;
            @(negedge clk);
        end
        check("R8", "unstrobed ones do not drop", carrier, 1'b1);
        check("R8", "no pulse during gap", carrier_chg, 1'b0);
        send_bit(1'b1, 1'b1);
        check("R8", "run register intact after gap", carrier, 1'b1);
    endtask

    initial begin
        t_reset();
        t_flag_after_reset();
        t_zero_fill();
        t_flag_run();
        t_idle_drop();
        t_conflict();
        t_no_strobe();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule